// File: doc/BRIEF.md
# Two-Stage Instruction Fetch with Skip and Jump Cancellation

This block sequences the program counter of a small two-stage microcontroller core with 12-bit instruction words. It is the fetch and instruction-register half of the core. Each cycle it drives a program-memory address and expects the word at that address back in the same cycle. On the next clock edge it captures that word into the instruction register. The register's contents go to the execute stage together with a valid flag.

Control-flow changes are handled by turning one prefetched word into a bubble: the all-zero NOP with the valid flag low. Skip instructions do this through the `skip_req` input, which the execute stage raises when its skip condition holds. A skip never touches the program counter. Jumps are recognised inside the block. When a valid instruction in the execute slot is a GOTO, the counter loads the jump target. The single word fetched sequentially behind the jump is dropped, and the word fetched from the target then enters execute intact. A bubble cannot itself request a skip, so a stray skip request can never reach the first instruction at a jump target.

Top module: `fetch_unit`

## Requirements
- R1: A synchronous reset sets `imem_addr` to the reset vector (parameter, default all ones: 0x7FF for an 11-bit PC). It also makes `exec_instr` read 12'h000 with `exec_valid` low.
- R2: In a cycle where no GOTO is taken, the next `imem_addr` is the current one plus 1, wrapping modulo 2^PC_W. The word on `imem_data` is presented on `exec_instr` the next cycle with `exec_valid` high, unless that cycle is cancelled.
- R3: A GOTO is a word with bits [11:9] equal to 3'b101 while `exec_valid` is high. The next cycle's `imem_addr` is then `{page_sel, exec_instr[8:0]}`.
- R4: The cycle after a GOTO is in execute, `exec_instr` is 12'h000 and `exec_valid` is low. The sequentially prefetched word is dropped.
- R5: Two cycles after a GOTO is in execute, the word read from the target is on `exec_instr`, unmodified, with `exec_valid` high.
- R6: When `skip_req` is high while `exec_valid` is high, the next cycle shows 12'h000 with `exec_valid` low. The next `imem_addr` still advances by exactly 1.
- R7: `skip_req` has no effect while `exec_valid` is low. The next instruction, including a jump target, is presented valid and unmodified.
- R8: Whenever `exec_valid` is low, `exec_instr` is 12'h000.
- R9: Consider the loop at 0x00B–0x00D: 12'h201 (timer to W, sets Z when zero), 12'h743 (skip if bit 2 of file 3, the Z flag, is set), 12'hA0B (GOTO 0x00B). Here 12'h201 executes on every pass. The loop leaves to 0x00E on the first pass that reads a zero timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| page_sel | input | PC_W-9 | Upper PC bits loaded on a GOTO |
| skip_req | input | 1 | Execute stage requests cancellation of the next instruction |
| imem_data | input | 12 | Program-memory word at `imem_addr`, same cycle |
| imem_addr | output | PC_W | Program-memory fetch address (current PC) |
| exec_instr | output | 12 | Instruction presented to execute |
| exec_valid | output | 1 | High when `exec_instr` is a real instruction, low for a bubble |

## Verification
The bench sweeps the timer start value, every page select and the presence of spurious skip requests during bubbles. It runs an architectural model of the three-instruction loop against the pipeline cycle by cycle. A design that flushed the jump-target word instead of the stale sequential word would execute the timer read only on the first pass. The loop would then spin forever or read a stale W, so the executed-word comparison and the pass count fail. A design that let a skip request outlive its slot, or honoured it in a bubble, would drop 12'h201 after the jump. The words just past each jump are distinct non-NOP literals, so a missed flush shows up as a wrong instruction executing. A skip that bumped the PC shows up as a wrong fetch address.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int INSTR_W = 12;
    localparam int TGT_W   = 9;
    localparam int OP_W    = 3;

    typedef logic [INSTR_W-1:0] instr_t;

    localparam instr_t         NOP_WORD = '0;
    localparam logic [OP_W-1:0] GOTO_OP = 3'b101;

    // Instruction register contents plus its valid marker
    typedef struct packed {
        instr_t instr;
        logic   valid;
    } ir_state_t;

    function automatic logic is_goto(input instr_t w);
        return w[INSTR_W-1 -: OP_W] == GOTO_OP;
    endfunction

    function automatic logic [TGT_W-1:0] goto_field(input instr_t w);
        return w[TGT_W-1:0];
    endfunction

endpackage

// File: rtl/fetch_decode.sv
module fetch_decode
    import fetch_pkg::*;
#(
    parameter int PC_W = 11
) (
    input  instr_t                  instr,
    input  logic                    valid,
    input  logic [PC_W-TGT_W-1:0]   page,
    output logic                    jump,
    output logic [PC_W-1:0]         target
);

    // A jump is only taken from a real instruction, never from a bubble
    always_comb begin
        jump   = valid && is_goto(instr);
        target = {page, goto_field(instr)};
    end

endmodule

// File: rtl/fetch_pc.sv
module fetch_pc
#(
    parameter int              PC_W      = 11,
    parameter logic [PC_W-1:0] RESET_VEC = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            jump,
    input  logic [PC_W-1:0] target,
    output logic [PC_W-1:0] pc
);

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;

    // Skips never reach this module: only a jump bends the sequence
    always_comb begin
        st_d = st_q;
        if (jump) begin
            st_d.pc = target;
        end else begin
            st_d.pc = st_q.pc + PC_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{pc: RESET_VEC};
        end else begin
            st_q <= st_d;
        end
    end

    assign pc = st_q.pc;

    // R2
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        !jump |=> (pc == $past(pc) + PC_W'(1)));

    // R3
    pc_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        jump |=> (pc == $past(target)));

endmodule

// File: rtl/fetch_ir.sv
module fetch_ir
    import fetch_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  instr_t word,
    input  logic   kill,
    output instr_t instr,
    output logic   valid
);

    ir_state_t st_d, st_q;

    // A cancelled slot is loaded with the NOP pattern and marked invalid
    always_comb begin
        st_d = st_q;
        if (kill) begin
            st_d.instr = NOP_WORD;
            st_d.valid = 1'b0;
        end else begin
            st_d.instr = word;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{instr: NOP_WORD, valid: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign instr = st_q.instr;
    assign valid = st_q.valid;

    // R8
    bubble_is_nop_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |-> (instr == NOP_WORD));

    // R4
    kill_bubble_chk: assert property (@(posedge clk) disable iff (rst)
        kill |=> !valid);

    // R2
    load_word_chk: assert property (@(posedge clk) disable iff (rst)
        !kill |=> (valid && instr == $past(word)));

endmodule

// File: rtl/fetch_unit.sv
module fetch_unit
    import fetch_pkg::*;
#(
    parameter int              PC_W      = 11,
    parameter logic [PC_W-1:0] RESET_VEC = '1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PC_W-TGT_W-1:0] page_sel,
    input  logic                  skip_req,
    input  instr_t                imem_data,
    output logic [PC_W-1:0]       imem_addr,
    output instr_t                exec_instr,
    output logic                  exec_valid
);

    logic            jump;
    logic [PC_W-1:0] target;
    logic            skip_take;
    logic            kill;
    logic [PC_W-1:0] pc;
    instr_t          ir_instr;
    logic            ir_valid;

    fetch_decode #(.PC_W(PC_W)) u_decode (
        .instr  (ir_instr),
        .valid  (ir_valid),
        .page   (page_sel),
        .jump   (jump),
        .target (target)
    );

    fetch_pc #(.PC_W(PC_W), .RESET_VEC(RESET_VEC)) u_pc (
        .clk    (clk),
        .rst    (rst),
        .jump   (jump),
        .target (target),
        .pc     (pc)
    );

    // A skip request only counts against a real instruction; it is not stored
    assign skip_take = skip_req && ir_valid;
    assign kill      = jump || skip_take;

    fetch_ir u_ir (
        .clk   (clk),
        .rst   (rst),
        .word  (imem_data),
        .kill  (kill),
        .instr (ir_instr),
        .valid (ir_valid)
    );

    assign imem_addr  = pc;
    assign exec_instr = ir_instr;
    assign exec_valid = ir_valid;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (imem_addr == RESET_VEC && !exec_valid && exec_instr == NOP_WORD));

    // R3
    goto_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_valid && is_goto(exec_instr)) |=>
            (imem_addr == {$past(page_sel), $past(exec_instr[TGT_W-1:0])}));

    // R5
    target_runs_chk: assert property (@(posedge clk) disable iff (rst)
        jump |=> ##1 (exec_valid && exec_instr == $past(imem_data)));

    // R6
    skip_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (skip_req && exec_valid && !jump) |=>
            (!exec_valid && imem_addr == $past(imem_addr) + PC_W'(1)));

    // R7
    bubble_no_skip_chk: assert property (@(posedge clk) disable iff (rst)
        !exec_valid |=> exec_valid);

endmodule

// File: tb/fetch_unit_bench.sv
`timescale 1ns/1ps
module fetch_unit_bench;
    import fetch_pkg::*;

    localparam int              PC_W   = 11;
    localparam int              PAGE_W = PC_W - TGT_W;
    localparam logic [PC_W-1:0] RVEC   = '1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [PAGE_W-1:0] page_sel = '0;
    logic              skip_req = 1'b0;
    logic [PC_W-1:0]   imem_addr;
    instr_t            imem_data;
    instr_t            exec_instr;
    logic              exec_valid;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // Program image repeated in every page; gap words are non-NOP literals
    function automatic instr_t prog(input logic [PC_W-1:0] a);
        case (a[TGT_W-1:0])
            9'h1FF:  return 12'hA0B;
            9'h00B:  return 12'h201;
            9'h00C:  return 12'h743;
            9'h00D:  return 12'hA0B;
            9'h00E:  return 12'hC05;
            9'h00F:  return 12'hA0F;
            default: return 12'hC3C;
        endcase
    endfunction

    assign imem_data = prog(imem_addr);

    fetch_unit #(.PC_W(PC_W), .RESET_VEC(RVEC)) u_fetch_unit (
        .clk        (clk),
        .rst        (rst),
        .page_sel   (page_sel),
        .skip_req   (skip_req),
        .imem_data  (imem_data),
        .imem_addr  (imem_addr),
        .exec_instr (exec_instr),
        .exec_valid (exec_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic run_loop(input int start, input int page, input bit noise);
        logic [PC_W-1:0] iss_pc;
        logic [PC_W-1:0] exp_addr;
        bit   exp_bubble;
        bit   z;
        int   tmr;
        int   movf_cnt;
        int   test_cnt;
        bit   exit_seen;
        instr_t w;

        rst      = 1'b1;
        page_sel = PAGE_W'(page);
        skip_req = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(imem_addr == RVEC, "R1 addr", int'(imem_addr), int'(RVEC));
        chk(!exec_valid && exec_instr == NOP_WORD, "R1 ir",
            int'({exec_valid, exec_instr}), 0);
        rst = 1'b0;

        iss_pc     = RVEC;
        exp_addr   = RVEC;
        exp_bubble = 1'b1;
        z          = 1'b0;
        tmr        = start;
        movf_cnt   = 0;
        test_cnt   = 0;
        exit_seen  = 1'b0;

        for (int c = 0; c < 4 * start + 24; c++) begin
            // R2/R3: fetch address follows sequence or jump target
            chk(imem_addr == exp_addr, "R2/R3 addr", int'(imem_addr), int'(exp_addr));
            if (exp_bubble) begin
                // R4/R6/R8: cancelled slot
                chk(!exec_valid && exec_instr == NOP_WORD, "R4/R6/R8 bubble",
                    int'({exec_valid, exec_instr}), 0);
                skip_req   = noise;
                exp_bubble = 1'b0;
                exp_addr   = imem_addr + PC_W'(1);
            end else begin
                w = prog(iss_pc);
                // R5/R7/R9: the architecturally next instruction is presented intact
                chk(exec_valid && exec_instr == w, "R5/R7/R9 exec",
                    int'({exec_valid, exec_instr}), int'({1'b1, w}));
                skip_req = 1'b0;
                exp_addr = imem_addr + PC_W'(1);
                if (w == 12'h201) begin
                    movf_cnt++;
                    z      = (tmr == 0);
                    tmr    = (tmr > 0) ? tmr - 1 : 0;
                    iss_pc = iss_pc + PC_W'(1);
                end else if (w == 12'h743) begin
                    test_cnt++;
                    if (z) begin
                        skip_req   = 1'b1;
                        exp_bubble = 1'b1;
                        iss_pc     = iss_pc + PC_W'(2);
                    end else begin
                        iss_pc = iss_pc + PC_W'(1);
                    end
                end else if (is_goto(w)) begin
                    iss_pc     = {PAGE_W'(page), goto_field(w)};
                    exp_addr   = iss_pc;
                    exp_bubble = 1'b1;
                end else begin
                    if (iss_pc[TGT_W-1:0] == 9'h00E) exit_seen = 1'b1;
                    iss_pc = iss_pc + PC_W'(1);
                end
            end
            @(negedge clk);
        end
        skip_req = 1'b0;
        // R9: timer read once per pass, loop leaves on the zero read
        chk(movf_cnt == start + 1, "R9 passes", movf_cnt, start + 1);
        chk(test_cnt == movf_cnt, "R9 test per pass", test_cnt, movf_cnt);
        chk(exit_seen, "R9 exit", int'(exit_seen), 1);
    endtask

    initial begin
        for (int s = 0; s < 6; s++) begin
            for (int p = 0; p < (1 << PAGE_W); p++) begin
                for (int n = 0; n < 2; n++) begin
                    run_loop(s, p, n[0]);
                end
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule